// File: doc/BRIEF.md
# Data Register File with Pointer-Based Indirect Access

This block is the 32-entry, byte-wide data register file of a small 8-bit core. The low addresses hold special-function registers: a timer byte, the low byte of the program counter, the status flags, a file pointer, an oscillator trim byte, an I/O port latch and two converter registers. General-purpose RAM fills the remaining addresses up to 0x1F. The core reads operands through a combinational read port and writes results through a write port. Both ports use a 5-bit file address, and the write lands on the clock edge that ends the instruction.

Address 0x00 holds no storage. Any access there is steered to the location named by the file pointer, which is how the core walks tables in RAM. The status byte sits between the datapath and software. The ALU pushes zero, digit-carry and carry results into it through dedicated update inputs, and those updates take precedence over a software write to the same bits in the same instruction. The two power-state bits cannot be written by software at all.

Top module: `regfile_indirect`

## Requirements
- R1: After reset, reading address 0x03 returns 0x18 (bit 4 and bit 3 set), address 0x04 returns 0xE0, address 0x02 returns 0xFF, and address 0x01 returns 0x00.
- R2: A write with `wr_en` high to any address other than 0x00 or 0x03 appears on `rd_data` from the next cycle. A read of that address in the cycle of the write returns the old value.
- R3: The pointer at address 0x04 stores only bits 4:0 of the written byte. Reading it always returns bits 7:5 as ones.
- R4: A read of address 0x00 with a non-zero pointer returns the contents of the location the pointer names.
- R5: A write to address 0x00 with a non-zero pointer updates the location the pointer names.
- R6: With the pointer at zero, a read of address 0x00 returns 0x00. A write to address 0x00 leaves all 31 readable locations unchanged.
- R7: Status bits 4 and 3 are never changed by a write.
- R8: When a status write coincides with any of `upd_z`, `upd_dc`, `upd_c`, the written bits 2:0 are discarded. Bits 7:5 are still written. Each flag whose update input is high takes its flag value (Z is bit 2, DC is bit 1, C is bit 0), and the other flags keep their value.
- R9: Writing 0x00 to the status byte together with a zero-flag update of 1 gives the pattern 000u_u1uu: bits 7:5 cleared, bit 2 set, bits 4, 3, 1 and 0 unchanged.
- R10: A flag update without a status write changes only the flagged status bits.
- R11: A status write with no flag update loads bits 7:5 and 2:0 from `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 5 | File address of the operand read |
| rd_data | output | 8 | Read value (combinational, pre-edge contents) |
| wr_en | input | 1 | Write enable for the destination write |
| wr_addr | input | 5 | File address of the destination |
| wr_data | input | 8 | Byte to write |
| upd_z | input | 1 | Instruction updates the zero flag |
| upd_dc | input | 1 | Instruction updates the digit-carry flag |
| upd_c | input | 1 | Instruction updates the carry flag |
| z_in | input | 1 | New zero-flag value |
| dc_in | input | 1 | New digit-carry value |
| c_in | input | 1 | New carry value |

## Verification
The assertions check on every cycle that the power-state bits never move, that each flagged status bit takes its flag input on the next edge, that an unflagged flag is protected during a status write that other flags update, that a zero pointer blocks indirect writes and makes indirect reads zero, and that pointer reads carry ones above bit 4. Some behaviours depend on what was stored earlier, and only the bench scenarios can show them: data written through one address path must read back through the other, a same-cycle read must return the old value, and a redirected write must leave every other location alone.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int NUM_LOC   = 1 << ADDR_W;

    // file map positions that the core decodes
    localparam int ADR_INDIRECT = 0;
    localparam int ADR_TIMER    = 1;
    localparam int ADR_PCLOW    = 2;
    localparam int ADR_STATUS   = 3;
    localparam int ADR_POINTER  = 4;
    localparam int ADR_TRIM     = 5;
    localparam int ADR_PORT     = 6;
    localparam int ADR_CNVCTL   = 7;
    localparam int ADR_CNVRES   = 8;
    localparam int FIRST_GPR    = 9;

    // status bit positions
    localparam int ST_C  = 0;
    localparam int ST_DC = 1;
    localparam int ST_Z  = 2;
    localparam int ST_PD = 3;
    localparam int ST_TO = 4;

    localparam logic [DATA_W-1:0] ST_RESET   = 8'h18;
    localparam logic [DATA_W-1:0] ST_WMASK   = 8'hE7;
    localparam logic [DATA_W-1:0] ST_UPPER   = 8'hE0;

    typedef struct packed {
        logic upd_z;
        logic upd_dc;
        logic upd_c;
        logic z;
        logic dc;
        logic c;
    } flag_req_t;

    function automatic logic [DATA_W-1:0] sfr_reset_value(input int idx);
        if (idx == ADR_PCLOW) return '1;
        return '0;
    endfunction

endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve #(
    parameter int ADDR_W = rf_pkg::ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              eff_valid
);
    always_comb begin
        eff_addr  = (addr == ADDR_W'(rf_pkg::ADR_INDIRECT)) ? ptr : addr;
        eff_valid = (eff_addr != ADDR_W'(rf_pkg::ADR_INDIRECT));
    end
endmodule

// File: rtl/rf_status.sv
module rf_status #(
    parameter int DATA_W = rf_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wd,
    input  rf_pkg::flag_req_t fr,
    output logic [DATA_W-1:0] status_q
);
    import rf_pkg::*;

    logic              protect;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        protect = fr.upd_z | fr.upd_dc | fr.upd_c;
        if (!we)          wmask = '0;
        else if (protect) wmask = ST_UPPER;
        else              wmask = ST_WMASK;
        nxt = (status_q & ~wmask) | (wd & wmask);
        if (fr.upd_z)  nxt[ST_Z]  = fr.z;
        if (fr.upd_dc) nxt[ST_DC] = fr.dc;
        if (fr.upd_c)  nxt[ST_C]  = fr.c;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= ST_RESET;
        else     status_q <= nxt;
    end

    // R7
    power_bits_stable_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(status_q[ST_TO]) && $stable(status_q[ST_PD]));

    // R8
    carry_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fr.upd_c |=> status_q[ST_C] == $past(fr.c));

    // R8
    zero_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fr.upd_z |=> status_q[ST_Z] == $past(fr.z));

    // R8
    dc_protected_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !fr.upd_dc && (fr.upd_z || fr.upd_c)) |=> $stable(status_q[ST_DC]));
endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int ADDR_W    = rf_pkg::ADDR_W,
    parameter int DATA_W    = rf_pkg::DATA_W,
    parameter int FIRST_GPR = rf_pkg::FIRST_GPR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ptr
);
    localparam int NUM_LOC = 1 << ADDR_W;
    localparam int PAD_W   = DATA_W - ADDR_W;

    logic [DATA_W-1:0] loc_q [NUM_LOC];
    logic [ADDR_W-1:0] ptr_q;

    assign loc_q[0] = '0;

    for (genvar i = 1; i < NUM_LOC; i++) begin : g_loc
        logic hit;
        assign hit = we && (waddr == ADDR_W'(i));
        if (i == rf_pkg::ADR_STATUS) begin : g_hole
            assign loc_q[i] = '0;
        end else if (i == rf_pkg::ADR_POINTER) begin : g_ptr
            always_ff @(posedge clk) begin
                if (rst)      ptr_q <= '0;
                else if (hit) ptr_q <= wd[ADDR_W-1:0];
            end
            assign loc_q[i] = {{PAD_W{1'b1}}, ptr_q};
        end else if (i < FIRST_GPR) begin : g_sfr
            logic [DATA_W-1:0] r_q;
            always_ff @(posedge clk) begin
                if (rst)      r_q <= rf_pkg::sfr_reset_value(i);
                else if (hit) r_q <= wd;
            end
            assign loc_q[i] = r_q;
        end else begin : g_gpr
            logic [DATA_W-1:0] r_q;
            always_ff @(posedge clk) begin
                if (hit) r_q <= wd;
            end
            assign loc_q[i] = r_q;
        end
    end

    assign rdata = loc_q[raddr];
    assign ptr   = ptr_q;

    // R3
    ptr_upper_ones_chk: assert property (@(posedge clk) disable iff (rst)
        loc_q[rf_pkg::ADR_POINTER][DATA_W-1:ADDR_W] == {PAD_W{1'b1}});
endmodule

// File: rtl/regfile_indirect.sv
module regfile_indirect #(
    parameter int ADDR_W = rf_pkg::ADDR_W,
    parameter int DATA_W = rf_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd_z,
    input  logic              upd_dc,
    input  logic              upd_c,
    input  logic              z_in,
    input  logic              dc_in,
    input  logic              c_in
);
    import rf_pkg::*;

    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] rd_eff, wr_eff;
    logic              rd_ok, wr_ok;
    logic              status_we, store_we;
    logic [DATA_W-1:0] status_q, store_rd;
    flag_req_t         fr;

    assign fr = '{upd_z: upd_z, upd_dc: upd_dc, upd_c: upd_c,
                  z: z_in, dc: dc_in, c: c_in};

    rf_addr_resolve #(.ADDR_W(ADDR_W)) u_rd_res (
        .addr(rd_addr), .ptr(ptr), .eff_addr(rd_eff), .eff_valid(rd_ok));

    rf_addr_resolve #(.ADDR_W(ADDR_W)) u_wr_res (
        .addr(wr_addr), .ptr(ptr), .eff_addr(wr_eff), .eff_valid(wr_ok));

    assign status_we = wr_en && wr_ok && (wr_eff == ADDR_W'(ADR_STATUS));
    assign store_we  = wr_en && wr_ok && (wr_eff != ADDR_W'(ADR_STATUS));

    rf_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst(rst), .we(status_we), .wd(wr_data),
        .fr(fr), .status_q(status_q));

    rf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .we(store_we), .waddr(wr_eff), .wd(wr_data),
        .raddr(rd_eff), .rdata(store_rd), .ptr(ptr));

    always_comb begin
        if (!rd_ok)                              rd_data = '0;
        else if (rd_eff == ADDR_W'(ADR_STATUS))  rd_data = status_q;
        else                                     rd_data = store_rd;
    end

    // R6
    null_ptr_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0 && ptr == '0) |-> rd_data == '0);

    // R6
    null_ptr_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_addr == '0 && ptr == '0) |-> !status_we && !store_we);

    // R3
    ptr_read_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(ADR_POINTER)) |-> rd_data[DATA_W-1:ADDR_W] == '1);
endmodule

// File: tb/tb_regfile_indirect.sv
`timescale 1ns/1ps
module tb_regfile_indirect;
    logic       clk = 0;
    logic       rst = 1;
    logic [4:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic       wr_en = 0;
    logic [4:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       upd_z = 0, upd_dc = 0, upd_c = 0, z_in = 0, dc_in = 0, c_in = 0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] mdl [32];

    always #2.5 clk = ~clk;

    regfile_indirect dut (.*);

    task automatic check(input logic [4:0] a, input logic [7:0] e, input string tag);
        rd_addr = a;
        #0.5;
        n_chk++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s addr=%0h got=%02h exp=%02h", tag, a, rd_data, e);
        end
    endtask

    function automatic logic [7:0] mdl_read(input logic [4:0] a);
        logic [4:0] e;
        e = (a == 0) ? mdl[4][4:0] : a;
        return (e == 0) ? 8'h00 : mdl[e];
    endfunction

    // fl = {uz, z, udc, dc, uc, c}
    task automatic apply(input logic we, input logic [4:0] a, input logic [7:0] d,
                         input logic [5:0] fl);
        logic [4:0] e;
        e = (a == 0) ? mdl[4][4:0] : a;
        wr_en = we; wr_addr = a; wr_data = d;
        {upd_z, z_in, upd_dc, dc_in, upd_c, c_in} = fl;
        @(posedge clk);
        if (we && e != 0) begin
            if (e == 3) begin
                mdl[3][7:5] = d[7:5];
                if (!(fl[5] | fl[3] | fl[1])) mdl[3][2:0] = d[2:0];
            end else if (e == 4) mdl[4] = {3'b111, d[4:0]};
            else mdl[e] = d;
        end
        if (fl[5]) mdl[3][2] = fl[4];
        if (fl[3]) mdl[3][1] = fl[2];
        if (fl[1]) mdl[3][0] = fl[0];
        @(negedge clk);
        wr_en = 0; {upd_z, z_in, upd_dc, dc_in, upd_c, c_in} = '0;
    endtask

    task automatic t_reset();
        mdl[1] = 8'h00; mdl[2] = 8'hFF; mdl[3] = 8'h18; mdl[4] = 8'hE0;
        for (int i = 5; i < 9; i++) mdl[i] = 8'h00;
        check(5'h03, 8'h18, "R1 status");
        check(5'h04, 8'hE0, "R1 pointer");
        check(5'h02, 8'hFF, "R1 pclow");
        check(5'h01, 8'h00, "R1 timer");
    endtask

    task automatic t_direct();
        for (int i = 9; i < 32; i++) apply(1, 5'(i), 8'(i * 7 + 3), '0);
        foreach (mdl[i]) if (i >= 9) check(5'(i), 8'(i * 7 + 3), "R2 gpr");
        apply(1, 5'h01, 8'h3C, '0); apply(1, 5'h02, 8'hC3, '0);
        for (int i = 5; i < 9; i++) apply(1, 5'(i), 8'(8'h90 + i), '0);
        check(5'h01, 8'h3C, "R2 timer"); check(5'h02, 8'hC3, "R2 pclow");
        for (int i = 5; i < 9; i++) check(5'(i), 8'(8'h90 + i), "R2 sfr");
        // same-cycle read returns old value
        rd_addr = 5'h10; wr_en = 1; wr_addr = 5'h10; wr_data = 8'h77;
        #0.5; n_chk++;
        if (rd_data !== mdl[16]) begin
            n_bad++; $display("FAIL R2 same-cycle got=%02h exp=%02h", rd_data, mdl[16]);
        end
        @(posedge clk); mdl[16] = 8'h77; @(negedge clk); wr_en = 0;
        check(5'h10, 8'h77, "R2 after edge");
    endtask

    task automatic t_pointer();
        apply(1, 5'h04, 8'h0A, '0); check(5'h04, 8'hEA, "R3 low bits");
        apply(1, 5'h04, 8'h35, '0); check(5'h04, 8'hF5, "R3 high bits dropped");
        apply(1, 5'h04, 8'h20, '0); check(5'h04, 8'hE0, "R3 zero");
    endtask

    task automatic t_indirect();
        apply(1, 5'h04, 8'h09, '0);
        check(5'h00, mdl[9], "R4 read via ptr 09");
        apply(1, 5'h00, 8'h5A, '0);
        check(5'h09, 8'h5A, "R5 write via ptr");
        apply(1, 5'h04, 8'h1F, '0);
        check(5'h00, mdl[31], "R4 read via ptr 1F");
        apply(1, 5'h00, 8'hA7, '0);
        check(5'h1F, 8'hA7, "R5 write top loc");
        check(5'h09, 8'h5A, "R5 neighbour kept");
    endtask

    task automatic t_ptr_zero();
        apply(1, 5'h04, 8'h00, '0);
        check(5'h00, 8'h00, "R6 null read");
        apply(1, 5'h00, 8'hA5, '0);
        for (int i = 1; i < 32; i++) check(5'(i), mdl[i], "R6 null write");
        check(5'h00, mdl_read(5'h00), "R6 null read again");
    endtask

    task automatic t_status();
        apply(1, 5'h03, 8'hFF, '0);
        check(5'h03, 8'hFF, "R11 load all writable");
        apply(1, 5'h03, 8'h00, '0);
        check(5'h03, 8'h18, "R7 power bits kept");
        apply(1, 5'h03, 8'hE7, 6'b000010);
        check(5'h03, 8'hF8, "R8 flags protected");
        apply(1, 5'h12, 8'h44, 6'b001111);
        check(5'h03, 8'hFB, "R10 flag only update");
        check(5'h12, 8'h44, "R10 data write");
        apply(1, 5'h03, 8'h00, 6'b110000);
        check(5'h03, 8'h1F, "R9 clear pattern");
        apply(1, 5'h04, 8'h03, '0);
        apply(1, 5'h00, 8'h02, 6'b100000);
        check(5'h03, 8'h1B, "R8 indirect status write protected");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_direct();
        t_pointer();
        t_indirect();
        t_ptr_zero();
        t_status();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule